// File: doc/BRIEF.md
# Chained Neuron Cell

This block is one cell of a fully connected neural layer. Many identical cells are chained. They share a set of broadcast control strobes, an address bus and a data bus, all driven by a central sequencer. Each cell holds a local memory of signed weights, one weight per input position of a frame.

In weight mode, a single write-permission token walks down the chain. Only the cell that holds the token stores the weights broadcast on the bus.

In accumulate mode, every cell multiplies each broadcast data word by its own weight at the broadcast address and adds the product into a wide accumulator. When a frame is complete, a copy strobe moves the sum into a mirror register. The mirror registers form a separate shift chain toward an output FIFO. This lets the next frame accumulate while earlier sums drain out through the chain.

Top module: `nn_cell`

## Requirements
- R1: `mode_ack` equals the value `wmode` had at the previous rising clock edge, and is 0 after reset.
- R2: While `wmode` is 1, a `tok_shift` strobe loads `tok_in` into the cell's token bit, and `tok_out` shows that bit. Without a strobe the bit holds its value. Whenever `wmode` is 0, the bit is cleared at the next edge.
- R3: A weight is written at `addr` from `bus_d` only in a cycle where `wmode`, the held token and `wvalid` are all 1. Once the token has shifted out of the cell, write attempts leave the stored weights unchanged.
- R4: An address at or above FRAME_LEN is never written, and it reads as a weight of zero.
- R5: An `acc_clear` strobe sets the accumulator to zero. When `acc_clear` and `acc_add` are both 1 in the same cycle, the clear wins and the add is dropped.
- R6: An `acc_add` strobe adds the signed product of `bus_d` and the weight stored at `addr`, sign-extended to ACC_W bits. The accumulator wraps in two's complement and does not saturate.
- R7: A `cpy` strobe loads the mirror register with the accumulator value, including every add strobed up to and including the cycle of the copy. `copy_ack` is 1 for exactly one cycle, two edges after the strobe is sampled. The mirror changes at that same second edge.
- R8: A `mir_shift` strobe loads `mir_in` into the mirror register at the sampling edge, and `mir_out` always shows the mirror register. If a copy load falls on the same edge, the copy wins.
- R9: After synchronous reset, `tok_out`, `mode_ack`, `copy_ack` and `mir_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wmode | input | 1 | Weight-load mode select |
| tok_shift | input | 1 | Advance the write token one cell |
| tok_in | input | 1 | Token from the previous cell |
| tok_out | output | 1 | Token held by this cell, toward the next cell |
| mode_ack | output | 1 | Registered acknowledge of weight mode |
| wvalid | input | 1 | Weight on `bus_d` is valid |
| acc_clear | input | 1 | Zero the accumulator |
| acc_add | input | 1 | Multiply-accumulate the current word |
| cpy | input | 1 | Copy the accumulator into the mirror register |
| copy_ack | output | 1 | Copy acknowledge pulse |
| mir_shift | input | 1 | Shift the mirror chain one step |
| addr | input | ADDR_W | Shared weight address |
| bus_d | input | DATA_W | Shared weight or data word |
| mir_in | input | ACC_W | Mirror value from the previous cell |
| mir_out | output | ACC_W | Mirror value toward the next cell or the output FIFO |

## Verification
The assertions assume that the sequencer never drives `tok_shift` or `wvalid` outside weight mode. They also assume that every strobe is a plain level sampled at a rising edge, with no relation required between strobes other than the collisions that R5 and R8 resolve. The stimulus drives every input on the falling edge, so each strobe covers exactly one rising edge. It keeps the mode stable across each whole load or frame sequence. Collisions are produced only on purpose: clear together with add, and a copy load landing on the same edge as a shift.

// File: rtl/nn_cell_pkg.sv
package nn_cell_pkg;

  typedef struct packed {
    logic clr;
    logic add;
    logic cpy;
  } mac_op_t;

endpackage

// File: rtl/nn_cell_wmem.sv
module nn_cell_wmem #(
  parameter int DEPTH = 784,
  parameter int AW    = 10,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] LIMIT = DEPTH[AW:0];

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             in_rng;

  assign idx    = addr[IDX_W-1:0];
  assign in_rng = ({1'b0, addr} < LIMIT);

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we && in_rng) mem[idx] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd <= '0;
    else if (in_rng) rd <= mem[idx];
    else             rd <= '0;
  end

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !in_rng |=> (rd == '0)); // R4

endmodule

// File: rtl/nn_cell_token.sv
module nn_cell_token (
  input  logic clk,
  input  logic rst,
  input  logic wmode,
  input  logic tok_shift,
  input  logic tok_in,
  output logic tok_q,
  output logic ack_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= wmode;
      if (!wmode)         tok_q <= 1'b0;
      else if (tok_shift) tok_q <= tok_in;
    end
  end

  AST_ACK_RISES: assert property (@(posedge clk) disable iff (rst)
    wmode |=> ack_q); // R1
  AST_ACK_FALLS: assert property (@(posedge clk) disable iff (rst)
    !wmode |=> !ack_q); // R1
  AST_TOK_DROPS: assert property (@(posedge clk) disable iff (rst)
    !wmode |=> !tok_q); // R2
  AST_TOK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wmode && tok_shift) |=> (tok_q == $past(tok_in))); // R2
  AST_TOK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wmode && !tok_shift) |=> $stable(tok_q)); // R2

endmodule

// File: rtl/nn_cell_mac.sv
module nn_cell_mac
  import nn_cell_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WW    = 16,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  mac_op_t          op,
  input  logic [DW-1:0]    din,
  input  logic [WW-1:0]    wgt,
  output logic [ACC_W-1:0] acc_nxt,
  output logic             load_mirror,
  output logic             ack_q
);
  localparam int PW  = DW + WW;
  localparam int EXT = ACC_W - PW;

  mac_op_t           op_q;
  logic [DW-1:0]     din_q;
  logic [ACC_W-1:0]  acc_q;
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]  prod_ext;

  // stage 1 lines up with the registered weight read
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      din_q <= '0;
    end else begin
      op_q  <= op;
      din_q <= din;
    end
  end

  assign prod     = $signed(din_q) * $signed(wgt);
  assign prod_ext = {{EXT{prod[PW-1]}}, prod};

  always_comb begin
    if (op_q.clr)      acc_nxt = '0;
    else if (op_q.add) acc_nxt = acc_q + prod_ext;
    else               acc_nxt = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ack_q <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      ack_q <= op_q.cpy;
    end
  end

  assign load_mirror = op_q.cpy;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    op.clr |=> ##1 (acc_q == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && !op.add) |=> ##1 $stable(acc_q)); // R6
  AST_COPY_ACKS: assert property (@(posedge clk) disable iff (rst)
    op.cpy |=> ##1 ack_q); // R7
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !op.cpy |=> ##1 !ack_q); // R7

endmodule

// File: rtl/nn_cell_mirror.sv
module nn_cell_mirror #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  input  logic             shift,
  input  logic [ACC_W-1:0] sin,
  output logic [ACC_W-1:0] mir_q
);
  always_ff @(posedge clk) begin
    if (rst)        mir_q <= '0;
    else if (load)  mir_q <= load_val;
    else if (shift) mir_q <= sin;
  end

  AST_SHIFT_TAKES_IN: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (mir_q == $past(sin))); // R8
  AST_COPY_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (mir_q == $past(load_val))); // R8

endmodule

// File: rtl/nn_cell.sv
module nn_cell
  import nn_cell_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WGT_W     = 16,
  parameter int ACC_W     = 48,
  parameter int FRAME_LEN = 784,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wmode,
  input  logic              tok_shift,
  input  logic              tok_in,
  output logic              tok_out,
  output logic              mode_ack,
  input  logic              wvalid,
  input  logic              acc_clear,
  input  logic              acc_add,
  input  logic              cpy,
  output logic              copy_ack,
  input  logic              mir_shift,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_d,
  input  logic [ACC_W-1:0]  mir_in,
  output logic [ACC_W-1:0]  mir_out
);
  logic             tok_q;
  logic             wr_en;
  logic [WGT_W-1:0] wgt_rd;
  logic [WGT_W-1:0] wgt_wd;
  logic [ACC_W-1:0] acc_nxt;
  logic             load_mirror;
  mac_op_t          op;

  nn_cell_token u_tok (
    .clk       (clk),
    .rst       (rst),
    .wmode     (wmode),
    .tok_shift (tok_shift),
    .tok_in    (tok_in),
    .tok_q     (tok_q),
    .ack_q     (mode_ack)
  );

  assign tok_out = tok_q;
  assign wr_en   = wmode && tok_q && wvalid;

  generate
    if (WGT_W <= DATA_W) begin : g_wtrim
      assign wgt_wd = bus_d[WGT_W-1:0];
    end else begin : g_wext
      assign wgt_wd = {{(WGT_W-DATA_W){bus_d[DATA_W-1]}}, bus_d};
    end
  endgenerate

  nn_cell_wmem #(
    .DEPTH (FRAME_LEN),
    .AW    (ADDR_W),
    .DW    (WGT_W)
  ) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .addr (addr),
    .wd   (wgt_wd),
    .rd   (wgt_rd)
  );

  assign op.clr = acc_clear;
  assign op.add = acc_add;
  assign op.cpy = cpy;

  nn_cell_mac #(
    .DW    (DATA_W),
    .WW    (WGT_W),
    .ACC_W (ACC_W)
  ) u_mac (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .din         (bus_d),
    .wgt         (wgt_rd),
    .acc_nxt     (acc_nxt),
    .load_mirror (load_mirror),
    .ack_q       (copy_ack)
  );

  nn_cell_mirror #(
    .ACC_W (ACC_W)
  ) u_mir (
    .clk      (clk),
    .rst      (rst),
    .load     (load_mirror),
    .load_val (acc_nxt),
    .shift    (mir_shift),
    .sin      (mir_in),
    .mir_q    (mir_out)
  );

  AST_TOKEN_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    tok_out |-> $past(wmode)); // R2

endmodule

// File: tb/sim_nn_cell.sv
module sim_nn_cell;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 16;
  localparam int AW = 10;
  localparam int ACCW = 48;
  localparam int FL = 16;

  // {weight, data} per address
  localparam logic [31:0] VEC [FL] = '{
    32'h0003_0005, 32'hFFFE_0007, 32'h7FFF_7FFF, 32'h8000_7FFF,
    32'h8000_8000, 32'h0001_FFFF, 32'h1234_0010, 32'hFF00_0100,
    32'h0000_1111, 32'h00FF_FF01, 32'h4000_4000, 32'hC000_4000,
    32'h0002_0002, 32'hFFFF_FFFF, 32'h0100_8001, 32'h7000_0003
  };

  logic clk = 1'b0;
  logic rst, wmode, tok_shift, tok_in, wvalid, acc_clear, acc_add, cpy, mir_shift;
  logic tok_out, mode_ack, copy_ack;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   bus_d;
  logic [ACCW-1:0] mir_in, mir_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nn_cell #(.FRAME_LEN(FL), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wmode(wmode), .tok_shift(tok_shift), .tok_in(tok_in),
    .tok_out(tok_out), .mode_ack(mode_ack), .wvalid(wvalid), .acc_clear(acc_clear),
    .acc_add(acc_add), .cpy(cpy), .copy_ack(copy_ack), .mir_shift(mir_shift),
    .addr(addr), .bus_d(bus_d), .mir_in(mir_in), .mir_out(mir_out)
  );

  task automatic chk(input string req, input logic [ACCW-1:0] act, input logic [ACCW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(input int i, input bit inv);
    return inv ? ~VEC[i][15:0] : VEC[i][15:0];
  endfunction

  function automatic logic [ACCW-1:0] exp_sum(input bit inv);
    longint s = 0;
    for (int i = 0; i < FL; i++)
      s += longint'($signed(VEC[i][31:16])) * longint'($signed(dat(i, inv)));
    return s[ACCW-1:0];
  endfunction

  task automatic write_all(input bit garbage);
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      addr = AW'(i); bus_d = garbage ? 16'h7FFF : VEC[i][31:16]; wvalid = 1'b1;
    end
    @(negedge clk); wvalid = 1'b0;
  endtask

  task automatic pulse_token(input logic v);
    @(negedge clk); tok_in = v; tok_shift = 1'b1;
    @(negedge clk); tok_shift = 1'b0;
  endtask

  // clear, add every address, copy; returns mirror after ack edge
  task automatic run_frame(input bit inv, output logic [ACCW-1:0] res, output logic ack);
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    for (int i = 0; i < FL; i++) begin
      addr = AW'(i); bus_d = dat(i, inv); acc_add = 1'b1;
      @(negedge clk);
    end
    acc_add = 1'b0; cpy = 1'b1;
    @(negedge clk); cpy = 1'b0;
    @(negedge clk); res = mir_out; ack = copy_ack;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [ACCW-1:0] res;
    logic ack;
    rst = 1'b1; wmode = 0; tok_shift = 0; tok_in = 0; wvalid = 0; acc_clear = 0;
    acc_add = 0; cpy = 0; mir_shift = 0; addr = '0; bus_d = '0; mir_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 tok_out", ACCW'(tok_out), '0);
    chk("R9 mode_ack", ACCW'(mode_ack), '0);
    chk("R9 copy_ack", ACCW'(copy_ack), '0);
    chk("R9 mir_out", mir_out, '0);

    wmode = 1'b1;
    @(negedge clk);
    chk("R1 ack high", ACCW'(mode_ack), 48'd1);
    pulse_token(1'b1);
    chk("R2 token taken", ACCW'(tok_out), 48'd1);
    @(negedge clk);
    chk("R2 token held", ACCW'(tok_out), 48'd1);
    write_all(1'b0);
    @(negedge clk); addr = AW'(20); bus_d = 16'h0005; wvalid = 1'b1;   // R4 out of range
    @(negedge clk); wvalid = 1'b0;
    pulse_token(1'b0);
    chk("R2 token passed on", ACCW'(tok_out), '0);
    write_all(1'b1);                                                   // R3 must be ignored
    @(negedge clk); wmode = 1'b0;
    @(negedge clk);
    chk("R1 ack low", ACCW'(mode_ack), '0);

    // table walk: two data patterns against the loaded weights
    for (int v = 0; v < 2; v++) begin
      run_frame(v[0], res, ack);
      chk("R6 R3 frame sum", res, exp_sum(v[0]));
      chk("R7 copy ack", ACCW'(ack), 48'd1);
      @(negedge clk);
      chk("R7 ack one cycle", ACCW'(copy_ack), '0);
    end

    // R4 out-of-range read is zero
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0; addr = AW'(20); bus_d = 16'h0003; acc_add = 1'b1;
    @(negedge clk); acc_add = 1'b0; cpy = 1'b1;
    @(negedge clk); cpy = 1'b0;
    @(negedge clk);
    chk("R4 oor weight zero", mir_out, '0);

    // R5 clear wins over add in same cycle
    @(negedge clk); addr = AW'(0); bus_d = 16'h0005; acc_add = 1'b1;
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0; acc_add = 1'b0; cpy = 1'b1;
    @(negedge clk); cpy = 1'b0;
    @(negedge clk);
    chk("R5 clear priority", mir_out, '0);

    // R8 plain shift, then collision with a copy load
    run_frame(1'b0, res, ack);
    @(negedge clk); mir_in = 48'h0000_1234_5678; mir_shift = 1'b1;
    @(negedge clk); mir_shift = 1'b0;
    chk("R8 shift loads mir_in", mir_out, 48'h0000_1234_5678);
    cpy = 1'b1;
    @(negedge clk); cpy = 1'b0; mir_shift = 1'b1; mir_in = 48'hABCD_0000_0001;
    @(negedge clk); mir_shift = 1'b0;
    chk("R8 copy beats shift", mir_out, exp_sum(1'b0));

    // R2 token dropped when mode falls
    @(negedge clk); wmode = 1'b1;
    pulse_token(1'b1);
    wmode = 1'b0;
    @(negedge clk);
    chk("R2 token cleared outside mode", ACCW'(tok_out), '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule